// File: doc/BRIEF.md
# Scrolling Video Fetch Address Generator

This block produces the word addresses that a display engine reads while it paints one bitplane frame. Software programs a start address as three byte registers, a per-line extra-word offset and a fine-scroll value. At every frame start, the start address is copied into a live 24-bit address counter. During each scan line the engine requests words one at a time, and every acknowledged fetch moves the counter on by one word (2 bytes). When the last word of the line is taken, the counter also skips the programmed line offset.

A nonzero fine-scroll value adds one extra 16-pixel group (4 words) to each line. This feeds the pixel shifter that displaces the picture sideways. The live counter can be read back one byte at a time and can also be written. A written value does not disturb the line in progress. It becomes the fetch address of the next scan line, so software can reposition the picture without waiting for the next frame.

Top module: `vid_fetch_addr`

## Requirements
- R1: After reset, `fetch_req` is 0, `fetch_addr` is 0 and every register reads back 0.
- R2: Writes to the start-address bytes (select 0 = bits 23:16, 1 = bits 15:8, 2 = bits 7:0) leave `fetch_addr` unchanged. The start address is copied into the live counter one cycle after `frame_start` is sampled high.
- R3: Bit 0 of the start-address low byte is always stored as 0, so the start address is always even.
- R4: A line accepted by `line_start` issues exactly 80 word requests when bits 3:0 of the scroll register (select 4) are zero, and 84 requests otherwise. The scroll value is sampled when the line starts, and later writes do not change that line.
- R5: Each acknowledged fetch that is not the last of its line raises `fetch_addr` by 2. With no acknowledge, `fetch_addr` holds.
- R6: After the last acknowledged fetch of a line, `fetch_addr` equals the last word address plus 2 plus twice the line-offset register (select 3), so a line advances by 2*(words + offset) bytes.
- R7: A write to the live counter bytes (select 5 = bits 23:16, 6 = bits 15:8, 7 = bits 7:0) does not change the addresses of the line in progress. The written value is the first fetch address of the next line.
- R8: A live counter write in the same cycle as the last acknowledge of a line wins. The line-offset advance is skipped, and the next address is the written value merged into the counter.
- R9: The live counter wraps modulo 2^24.
- R10: A `line_start` pulse while a line is still fetching is ignored. `fetch_req` is 0 when no line is active.
- R11: `reg_rdata` returns the selected register for selects 0 to 4 and the live counter byte for selects 5 to 7.
- R12: `frame_start` takes priority over everything else. It ends an active line and discards any live counter write still waiting for a line boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register select (0-2 start address, 3 line offset, 4 scroll, 5-7 live counter) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_sel` |
| frame_start | input | 1 | Frame start strobe from the timing generator |
| line_start | input | 1 | Scan line start strobe from the timing generator |
| fetch_req | output | 1 | Word fetch request |
| fetch_ack | input | 1 | Word fetch acknowledge |
| fetch_addr | output | 24 | Current fetch byte address |

## Verification
The hardest case to reach from the ports is a live counter write that lands in exactly the cycle of a line's final acknowledge. In that cycle both the overwrite and the line-offset skip compete for the counter. The bench drives the acknowledge itself and counts each accepted word. It then drives the byte write on the very acknowledge it knows to be the 80th, and confirms that the following line starts at the merged written value rather than at the advanced one. Mid-line writes, gapped acknowledges, a late scroll change and a stray `line_start` are each injected at a chosen word index in the same way.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
  localparam int ADDR_W   = 24;
  localparam int BYTE_W   = 8;
  localparam int SCROLL_W = 4;

  typedef enum logic [2:0] {
    SEL_BASE_HI = 3'd0,
    SEL_BASE_MD = 3'd1,
    SEL_BASE_LO = 3'd2,
    SEL_LINE_OF = 3'd3,
    SEL_SCROLL  = 3'd4,
    SEL_CNT_HI  = 3'd5,
    SEL_CNT_MD  = 3'd6,
    SEL_CNT_LO  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/vfa_regs.sv
module vfa_regs
  import vfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] live_cnt,
  output logic [BYTE_W-1:0] rdata,
  output logic [ADDR_W-1:0] base_addr,
  output logic [BYTE_W-1:0] line_off,
  output logic [BYTE_W-1:0] scroll,
  output logic              cnt_wr,
  output logic [1:0]        cnt_byte,
  output logic [BYTE_W-1:0] cnt_wdata
);
  logic [BYTE_W-1:0] hi_q, md_q, lo_q, off_q, scr_q;
  logic [BYTE_W-1:0] hi_d, md_d, lo_d, off_d, scr_d;
  reg_sel_e sel_e;

  assign sel_e = reg_sel_e'(sel);

  always_comb begin
    hi_d  = hi_q;
    md_d  = md_q;
    lo_d  = lo_q;
    off_d = off_q;
    scr_d = scr_q;
    if (wr_en) begin
      case (sel_e)
        SEL_BASE_HI: hi_d  = wdata;
        SEL_BASE_MD: md_d  = wdata;
        SEL_BASE_LO: lo_d  = {wdata[BYTE_W-1:1], 1'b0};
        SEL_LINE_OF: off_d = wdata;
        SEL_SCROLL:  scr_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      md_q  <= '0;
      lo_q  <= '0;
      off_q <= '0;
      scr_q <= '0;
    end else if (wr_en) begin
      hi_q  <= hi_d;
      md_q  <= md_d;
      lo_q  <= lo_d;
      off_q <= off_d;
      scr_q <= scr_d;
    end
  end

  // live counter byte writes are decoded here, applied by the counter
  always_comb begin
    cnt_wr    = 1'b0;
    cnt_byte  = 2'd0;
    cnt_wdata = wdata;
    case (sel_e)
      SEL_CNT_HI: begin cnt_wr = wr_en; cnt_byte = 2'd2; end
      SEL_CNT_MD: begin cnt_wr = wr_en; cnt_byte = 2'd1; end
      SEL_CNT_LO: begin cnt_wr = wr_en; cnt_byte = 2'd0; end
      default: ;
    endcase
  end

  always_comb begin
    case (sel_e)
      SEL_BASE_HI: rdata = hi_q;
      SEL_BASE_MD: rdata = md_q;
      SEL_BASE_LO: rdata = lo_q;
      SEL_LINE_OF: rdata = off_q;
      SEL_SCROLL:  rdata = scr_q;
      SEL_CNT_HI:  rdata = live_cnt[23:16];
      SEL_CNT_MD:  rdata = live_cnt[15:8];
      default:     rdata = live_cnt[7:0];
    endcase
  end

  assign base_addr = {hi_q, md_q, lo_q};
  assign line_off  = off_q;
  assign scroll    = scr_q;

  assert_base_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[0] == 1'b0);
endmodule

// File: rtl/vfa_line_ctl.sv
module vfa_line_ctl
  import vfa_pkg::*;
#(
  parameter int WORDS_PER_LINE = 80,
  parameter int GROUP_WORDS    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic [SCROLL_W-1:0] scroll,
  input  logic                fetch_ack,
  output logic                fetch_req,
  output logic                line_begin,
  output logic                word_adv,
  output logic                line_end
);
  localparam int CNT_W = $clog2(WORDS_PER_LINE + GROUP_WORDS + 1);
  localparam logic [CNT_W-1:0] PLAIN_LEN  = CNT_W'(WORDS_PER_LINE);
  localparam logic [CNT_W-1:0] SCROLL_LEN = CNT_W'(WORDS_PER_LINE + GROUP_WORDS);

  logic             active_q, active_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic             last_word;

  assign fetch_req  = active_q;
  assign line_begin = line_start && !active_q && !frame_start;
  assign word_adv   = active_q && fetch_ack && !frame_start;
  assign last_word  = (wcnt_q == limit_q - 1'b1);
  assign line_end   = word_adv && last_word;

  always_comb begin
    active_d = active_q;
    wcnt_d   = wcnt_q;
    limit_d  = limit_q;
    if (frame_start) begin
      active_d = 1'b0;
      wcnt_d   = '0;
    end else if (line_begin) begin
      active_d = 1'b1;
      wcnt_d   = '0;
      limit_d  = (scroll != '0) ? SCROLL_LEN : PLAIN_LEN;
    end else if (line_end) begin
      active_d = 1'b0;
      wcnt_d   = '0;
    end else if (word_adv) begin
      wcnt_d   = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wcnt_q   <= '0;
      limit_q  <= PLAIN_LEN;
    end else begin
      active_q <= active_d;
      wcnt_q   <= wcnt_d;
      limit_q  <= limit_d;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (wcnt_q < limit_q));

  assert_scroll_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !frame_start && !line_end |=> fetch_req && $stable(limit_q));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && line_start && !fetch_ack && !frame_start |=> fetch_req && $stable(wcnt_q));
endmodule

// File: rtl/vfa_addr_ctr.sv
module vfa_addr_ctr
  import vfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              line_begin,
  input  logic              word_adv,
  input  logic              line_end,
  input  logic [BYTE_W-1:0] line_off,
  input  logic              cnt_wr,
  input  logic [1:0]        cnt_byte,
  input  logic [BYTE_W-1:0] cnt_wdata,
  output logic [ADDR_W-1:0] cnt
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] pend_val_q, pend_val_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] merge_src, merged, skip_bytes;
  logic              pend_now;

  assign skip_bytes = {{(ADDR_W-BYTE_W-1){1'b0}}, line_off, 1'b0};
  assign merge_src  = pend_q ? pend_val_q : cnt_q;

  always_comb begin
    merged = merge_src;
    case (cnt_byte)
      2'd2:    merged[23:16] = cnt_wdata;
      2'd1:    merged[15:8]  = cnt_wdata;
      default: merged[7:0]   = cnt_wdata;
    endcase
  end

  assign pend_val_d = cnt_wr ? merged : pend_val_q;
  assign pend_now   = pend_q || cnt_wr;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_now;
    if (frame_start) begin
      cnt_d  = base_addr;
      pend_d = 1'b0;
    end else if (line_end) begin
      cnt_d  = pend_now ? pend_val_d : cnt_q + WORD_BYTES + skip_bytes;
      pend_d = 1'b0;
    end else if (line_begin && pend_now) begin
      cnt_d  = pend_val_d;
      pend_d = 1'b0;
    end else if (word_adv) begin
      cnt_d  = cnt_q + WORD_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      if (cnt_wr) pend_val_q <= pend_val_d;
    end
  end

  assign cnt = cnt_q;

  assert_frame_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cnt_q == $past(base_addr));

  assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_adv && !line_end && !frame_start |=> cnt_q == $past(cnt_q) + WORD_BYTES);

  assert_line_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !frame_start && !pend_q && !cnt_wr
      |=> cnt_q == $past(cnt_q) + WORD_BYTES + $past(skip_bytes));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && cnt_wr && !frame_start |=> cnt_q == $past(merged));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start && !line_end && !word_adv && !(line_begin && pend_now) |=> $stable(cnt_q));
endmodule

// File: rtl/vid_fetch_addr.sv
module vid_fetch_addr
  import vfa_pkg::*;
#(
  parameter int WORDS_PER_LINE = 80,
  parameter int GROUP_WORDS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        frame_start,
  input  logic        line_start,
  output logic        fetch_req,
  input  logic        fetch_ack,
  output logic [23:0] fetch_addr
);
  logic [ADDR_W-1:0] base_addr, live_cnt;
  logic [BYTE_W-1:0] line_off, scroll, cnt_wdata;
  logic              cnt_wr, line_begin, word_adv, line_end;
  logic [1:0]        cnt_byte;

  vfa_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .live_cnt  (live_cnt),
    .rdata     (reg_rdata),
    .base_addr (base_addr),
    .line_off  (line_off),
    .scroll    (scroll),
    .cnt_wr    (cnt_wr),
    .cnt_byte  (cnt_byte),
    .cnt_wdata (cnt_wdata)
  );

  vfa_line_ctl #(
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .GROUP_WORDS    (GROUP_WORDS)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .scroll      (scroll[SCROLL_W-1:0]),
    .fetch_ack   (fetch_ack),
    .fetch_req   (fetch_req),
    .line_begin  (line_begin),
    .word_adv    (word_adv),
    .line_end    (line_end)
  );

  vfa_addr_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .base_addr   (base_addr),
    .line_begin  (line_begin),
    .word_adv    (word_adv),
    .line_end    (line_end),
    .line_off    (line_off),
    .cnt_wr      (cnt_wr),
    .cnt_byte    (cnt_byte),
    .cnt_wdata   (cnt_wdata),
    .cnt         (live_cnt)
  );

  assign fetch_addr = live_cnt;

  assert_idle_after_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !fetch_req);
endmodule

// File: tb/vid_fetch_addr_test.sv
module vid_fetch_addr_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        fetch_req;
  logic        fetch_ack = 1'b0;
  logic [23:0] fetch_addr;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  vid_fetch_addr uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .line_start(line_start), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr)
  );

  // {start address, line offset, scroll}
  localparam logic [39:0] VEC [5] = '{
    {24'h010000, 8'd0,   8'h00},
    {24'h020100, 8'd80,  8'h00},
    {24'h03ABC2, 8'd4,   8'h03},
    {24'h100000, 8'd160, 8'h10},
    {24'h000302, 8'd255, 8'h0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // mode: 0 none, 1 full counter write at acks k..k+2, 2 low counter byte at ack k,
  //       3 line_start pulse at ack k, 4 scroll write at ack k
  task automatic run_line(input logic [23:0] start, input int nw, input int mode,
                          input int k, input logic [23:0] val, input bit gap);
    logic [23:0] exp;
    int n;
    exp = start;
    n = 0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    for (int i = 0; i < 200 && fetch_req; i++) begin
      check("R5", fetch_addr, exp, "word address");
      fetch_ack = 1'b1;
      if (mode == 1 && i >= k && i < k + 3) begin
        reg_wr = 1'b1; reg_sel = 3'(5 + i - k);
        reg_wdata = (i == k) ? val[23:16] : (i == k + 1) ? val[15:8] : val[7:0];
      end
      if (mode == 2 && i == k) begin reg_wr = 1'b1; reg_sel = 3'd7; reg_wdata = val[7:0]; end
      if (mode == 3 && i == k) line_start = 1'b1;
      if (mode == 4 && i == k) begin reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h07; end
      @(negedge clk);
      fetch_ack = 1'b0; reg_wr = 1'b0; line_start = 1'b0;
      exp = exp + 24'd2;
      n++;
      if (gap && fetch_req) begin
        @(negedge clk);
        check("R5", fetch_addr, exp, "hold without ack");
      end
    end
    check("R4", n, nw, "words in line");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] b, e;
    logic [7:0] off, scr;
    int nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", fetch_req, 0, "req after reset");
    check("R1", fetch_addr, 0, "addr after reset");
    for (int s = 0; s < 8; s++) begin
      reg_sel = 3'(s); #1;
      check("R1", reg_rdata, 0, "register after reset");
    end

    // vector table
    for (int v = 0; v < 5; v++) begin
      b = VEC[v][39:16]; off = VEC[v][15:8]; scr = VEC[v][7:0];
      nw = (scr[3:0] != 4'd0) ? 84 : 80;
      wr(3'd0, b[23:16]); wr(3'd1, b[15:8]); wr(3'd2, b[7:0]);
      wr(3'd3, off); wr(3'd4, scr);
      pulse_frame();
      check("R2", fetch_addr, b, "frame load");
      run_line(b, nw, 0, 0, 24'h0, 1'b0);
      e = b + 24'(2 * (nw + int'(off)));
      check("R6", fetch_addr, e, "line advance");
      run_line(e, nw, 0, 0, 24'h0, v == 2);
      e = e + 24'(2 * (nw + int'(off)));
      check("R6", fetch_addr, e, "second line advance");
    end

    // R2: base writes do not move the address; R3: low bit forced even; R11 readback
    e = fetch_addr;
    wr(3'd0, 8'hAB); wr(3'd1, 8'hCD); wr(3'd2, 8'h77);
    check("R2", fetch_addr, e, "no immediate effect");
    reg_sel = 3'd2; #1; check("R3", reg_rdata, 8'h76, "low byte even");
    reg_sel = 3'd0; #1; check("R11", reg_rdata, 8'hAB, "high byte readback");
    reg_sel = 3'd5; #1; check("R11", reg_rdata, e[23:16], "counter high readback");
    reg_sel = 3'd7; #1; check("R11", reg_rdata, e[7:0], "counter low readback");
    wr(3'd3, 8'd0); wr(3'd4, 8'h00);
    pulse_frame();
    check("R3", fetch_addr, 24'hABCD76, "even start");

    // R4: scroll change mid-line has no effect on that line, applies to next
    run_line(24'hABCD76, 80, 4, 10, 24'h0, 1'b0);
    e = 24'hABCD76 + 24'd160;
    run_line(e, 84, 0, 0, 24'h0, 1'b0);
    wr(3'd4, 8'h00);

    // R10: stray line_start during a line is ignored
    e = fetch_addr;
    run_line(e, 80, 3, 20, 24'h0, 1'b0);
    check("R10", fetch_req, 0, "idle after line");
    check("R10", fetch_addr, e + 24'd160, "line unaffected");

    // R7: counter write mid-line takes effect at next line
    e = fetch_addr;
    run_line(e, 80, 1, 30, 24'h123456, 1'b0);
    check("R7", fetch_addr, 24'h123456, "written value after line");
    run_line(24'h123456, 80, 0, 0, 24'h0, 1'b0);

    // R7: counter write while idle is not visible until line start
    e = fetch_addr;
    wr(3'd5, 8'h44); wr(3'd6, 8'h55); wr(3'd7, 8'h66);
    check("R7", fetch_addr, e, "idle write deferred");
    run_line(24'h445566, 80, 0, 0, 24'h0, 1'b0);

    // R8: write on the last ack wins over the line skip
    wr(3'd3, 8'd50);
    e = fetch_addr;
    run_line(e, 80, 2, 79, 24'h000040, 1'b0);
    b = e + 24'd158;
    check("R8", fetch_addr, {b[23:8], 8'h40}, "write beats advance");

    // R9: wrap modulo 2^24
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hF0); wr(3'd3, 8'd0);
    pulse_frame();
    run_line(24'hFFFFF0, 80, 0, 0, 24'h0, 1'b0);
    check("R9", fetch_addr, 24'h000090, "wrapped line end");

    // R12: frame start discards a waiting counter write and aborts a line
    wr(3'd5, 8'h77); wr(3'd6, 8'h00); wr(3'd7, 8'h00);
    pulse_frame();
    check("R12", fetch_addr, 24'hFFFFF0, "frame load over pending");
    run_line(24'hFFFFF0, 80, 0, 0, 24'h0, 1'b0);
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    check("R12", fetch_req, 1, "line active");
    pulse_frame();
    check("R12", fetch_req, 0, "frame ends line");
    check("R12", fetch_addr, 24'hFFFFF0, "frame reload");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule